// File: doc/BRIEF.md
# Three-Port Forwarding State and Mirror Filter

This block makes the final egress decision for every frame received by a three-port switch. Upstream logic presents the port the frame arrived on and a destination port mask, which is either learned or flooded. The block then applies each port's spanning-tree state to both the ingress side and the egress side. It adds a sniffer port when the mirroring configuration asks for one. It returns the final egress port mask and a flag that allows source-address learning for the frame. The result appears one clock after the request.

Two configuration registers set the behaviour: a per-port state register and a mirror register. Both are written through a plain write port. A mode used in practice isolates the two external ports from each other while sending all their traffic to the host-facing port. To do this, both external ports are placed in the blocking state, and the host-facing port is made the sniffer with sniff-all receive mirroring. Blocked ingress traffic still reaches the sniffer, but ordinary forwarding between the blocked ports is suppressed.

Top module: `swf_egress_filter`

## Requirements
- R1: While reset is asserted, and after it is released, `dec_valid`, `dec_emask` and `dec_learn` are 0. Reset sets the state register to all ports forwarding (value 0) and the mirror register to 0.
- R2: A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata[5:0]` into the state register. Port p owns bits [2p+1:2p], coded 0 forwarding, 1 blocking, 2 learning, 3 disabled. With `cfg_sel`=1 the write loads `cfg_wdata[8:0]` into the mirror register.
- R3: A request presented with `req_valid`=1 in one cycle produces its decision, with `dec_valid`=1, after the next rising edge. In a cycle that follows no request, all outputs are 0.
- R4: When the ingress port is forwarding, the normal egress mask is `req_dmask` restricted to ports whose state is forwarding.
- R5: When the ingress port is blocking, learning or disabled, the normal egress mask is empty.
- R6: `dec_learn` is 1 only when the ingress port is in the learning or the forwarding state.
- R7: Mirror register layout: bit 8 is sniff-all, bits 7:5 select the sniffer port(s) (bit 5+p for port p), bits 4:2 mark mirrored ports (bit 2+p for port p), bit 1 enables receive mirroring and bit 0 enables transmit mirroring. With both enable bits clear, no sniffer port is added.
- R8: With receive mirroring enabled and the ingress port mirrored, the sniffer port is added when the ingress port is forwarding. When sniff-all is set, it is also added when the ingress port is blocking or learning, but never when the ingress port is disabled.
- R9: With transmit mirroring enabled, the sniffer port is added when the normal egress mask includes a mirrored port.
- R10: The ingress port is never set in `dec_emask`, even when it is the sniffer.
- R11: A register write takes effect for requests from the cycle after the write cycle onwards. A request in the same cycle as the write uses the old value.
- R12: An ingress index of 3 or more (no such port) yields an empty mask and `dec_learn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the state register, 1 the mirror register |
| cfg_wdata | input | 9 | Write data |
| req_valid | input | 1 | Frame decision request |
| req_src | input | 2 | Ingress port index |
| req_dmask | input | 3 | Learned or flooded destination mask, bit p = port p |
| dec_valid | output | 1 | Decision valid |
| dec_emask | output | 3 | Final egress port mask |
| dec_learn | output | 1 | Address learning allowed |

## Verification
A configuration write and a frame decision can fall in the same cycle. The bench provokes this by driving a write that disables the ingress port in the same cycle as a request from that port. It judges the result by requiring the old (forwarding) result for that request and the disabled result for the next one. Receive and transmit mirroring can also both trigger for one frame. Separately, the sniff-all path competes with the blocking state of the ingress port. Table vectors cover each combination, and each expected mask is worked out from the register fields by hand.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef enum logic [1:0] {
    PS_FWD = 2'd0,
    PS_BLK = 2'd1,
    PS_LRN = 2'd2,
    PS_DIS = 2'd3
  } pstate_e;

  localparam int ST_W = 2;
  localparam logic SEL_STATE  = 1'b0;
  localparam logic SEL_MIRROR = 1'b1;

endpackage

// File: rtl/swf_cfg_regs.sv
module swf_cfg_regs
  import swf_pkg::*;
#(
  parameter int N_PORTS = 3,
  localparam int STATE_W = ST_W * N_PORTS,
  localparam int MIR_W   = 2 * N_PORTS + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [MIR_W-1:0]   cfg_wdata,
  output logic [STATE_W-1:0] state_q,
  output logic [MIR_W-1:0]   mirror_q
);

  logic               state_en, mirror_en;
  logic [STATE_W-1:0] state_d;
  logic [MIR_W-1:0]   mirror_d;

  always_comb begin
    state_en  = cfg_we && (cfg_sel == SEL_STATE);
    mirror_en = cfg_we && (cfg_sel == SEL_MIRROR);
    state_d   = cfg_wdata[STATE_W-1:0];
    mirror_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mirror_q <= '0;
    end else if (mirror_en) begin
      mirror_q <= mirror_d;
    end
  end

endmodule

// File: rtl/swf_port_gate.sv
module swf_port_gate
  import swf_pkg::*;
#(
  parameter int N_PORTS = 3,
  localparam int STATE_W = ST_W * N_PORTS,
  localparam int PIDX_W  = $clog2(N_PORTS + 1)
) (
  input  logic [STATE_W-1:0] state_q,
  input  logic [PIDX_W-1:0]  src,
  output logic [N_PORTS-1:0] egr_fwd,
  output logic [N_PORTS-1:0] src_oh,
  output pstate_e            src_state,
  output logic               src_valid
);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign egr_fwd[p] = (pstate_e'(state_q[ST_W*p +: ST_W]) == PS_FWD);
    assign src_oh[p]  = (src == PIDX_W'(p));
  end

  always_comb begin
    src_state = PS_DIS;
    for (int p = 0; p < N_PORTS; p++) begin
      if (src_oh[p]) src_state = pstate_e'(state_q[ST_W*p +: ST_W]);
    end
    src_valid = |src_oh;
  end

endmodule

// File: rtl/swf_mirror.sv
module swf_mirror
  import swf_pkg::*;
#(
  parameter int N_PORTS = 3,
  localparam int MIR_W     = 2 * N_PORTS + 3,
  localparam int RX_BIT    = 1,
  localparam int TX_BIT    = 0,
  localparam int MIRD_LO   = 2,
  localparam int SNIF_LO   = MIRD_LO + N_PORTS,
  localparam int SALL_BIT  = SNIF_LO + N_PORTS
) (
  input  logic [MIR_W-1:0]   mirror_q,
  input  logic [N_PORTS-1:0] src_oh,
  input  pstate_e            src_state,
  input  logic [N_PORTS-1:0] normal_mask,
  output logic [N_PORTS-1:0] final_mask
);

  logic               sniff_all, rx_en, tx_en;
  logic [N_PORTS-1:0] sniffer, mirrored;
  logic               src_mirrored, src_admits, rx_hit, tx_hit;

  always_comb begin
    sniff_all    = mirror_q[SALL_BIT];
    sniffer      = mirror_q[SNIF_LO +: N_PORTS];
    mirrored     = mirror_q[MIRD_LO +: N_PORTS];
    rx_en        = mirror_q[RX_BIT];
    tx_en        = mirror_q[TX_BIT];
    src_mirrored = |(mirrored & src_oh);
    src_admits   = (src_state == PS_FWD) ||
                   (sniff_all && (src_state != PS_DIS));
    rx_hit       = rx_en && src_mirrored && src_admits;
    tx_hit       = tx_en && (|(normal_mask & mirrored));
    final_mask   = (normal_mask | ((rx_hit || tx_hit) ? sniffer : '0)) & ~src_oh;
  end

endmodule

// File: rtl/swf_egress_filter.sv
module swf_egress_filter
  import swf_pkg::*;
#(
  parameter int N_PORTS = 3,
  localparam int STATE_W = ST_W * N_PORTS,
  localparam int MIR_W   = 2 * N_PORTS + 3,
  localparam int PIDX_W  = $clog2(N_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [MIR_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  input  logic [PIDX_W-1:0]  req_src,
  input  logic [N_PORTS-1:0] req_dmask,
  output logic               dec_valid,
  output logic [N_PORTS-1:0] dec_emask,
  output logic               dec_learn
);

  logic [STATE_W-1:0] state_q;
  logic [MIR_W-1:0]   mirror_q;
  logic [N_PORTS-1:0] egr_fwd, src_oh, normal_mask, final_mask;
  pstate_e            src_state;
  logic               src_valid, learn_ok;

  logic               valid_d, learn_d;
  logic [N_PORTS-1:0] emask_d;

  swf_cfg_regs #(.N_PORTS(N_PORTS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .state_q   (state_q),
    .mirror_q  (mirror_q)
  );

  swf_port_gate #(.N_PORTS(N_PORTS)) u_gate (
    .state_q   (state_q),
    .src       (req_src),
    .egr_fwd   (egr_fwd),
    .src_oh    (src_oh),
    .src_state (src_state),
    .src_valid (src_valid)
  );

  always_comb begin
    normal_mask = (src_state == PS_FWD) ? (req_dmask & egr_fwd & ~src_oh) : '0;
    learn_ok    = src_valid && ((src_state == PS_FWD) || (src_state == PS_LRN));
  end

  swf_mirror #(.N_PORTS(N_PORTS)) u_mirror (
    .mirror_q    (mirror_q),
    .src_oh      (src_oh),
    .src_state   (src_state),
    .normal_mask (normal_mask),
    .final_mask  (final_mask)
  );

  always_comb begin
    valid_d = req_valid;
    emask_d = req_valid ? final_mask : '0;
    learn_d = req_valid && learn_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_emask <= '0;
      dec_learn <= 1'b0;
    end else begin
      dec_valid <= valid_d;
      dec_emask <= emask_d;
      dec_learn <= learn_d;
    end
  end

endmodule

// File: rtl/swf_egress_filter_chk.sv
module swf_egress_filter_chk
  import swf_pkg::*;
#(
  parameter int N_PORTS = 3,
  localparam int STATE_W = ST_W * N_PORTS,
  localparam int MIR_W   = 2 * N_PORTS + 3,
  localparam int PIDX_W  = $clog2(N_PORTS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [PIDX_W-1:0]  req_src,
  input logic               dec_valid,
  input logic [N_PORTS-1:0] dec_emask,
  input logic               dec_learn,
  input logic [STATE_W-1:0] state_q,
  input logic [MIR_W-1:0]   mirror_q
);

  logic [N_PORTS-1:0] in_oh, fwd_ports, snf_ports;
  pstate_e            in_st;
  logic               in_ok;

  always_comb begin
    in_oh     = '0;
    fwd_ports = '0;
    in_st     = PS_DIS;
    for (int p = 0; p < N_PORTS; p++) begin
      if (req_src == PIDX_W'(p)) begin
        in_oh[p] = 1'b1;
        in_st    = pstate_e'(state_q[ST_W*p +: ST_W]);
      end
      fwd_ports[p] = (state_q[ST_W*p +: ST_W] == 2'd0);
    end
    in_ok     = |in_oh;
    snf_ports = mirror_q[2+N_PORTS +: N_PORTS];
  end

  AST_DECISION_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && dec_emask == '0 && !dec_learn)); // R3

  AST_NO_SELF_EGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((dec_emask & $past(in_oh)) == '0)); // R10

  AST_LEARN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_st != PS_FWD && in_st != PS_LRN) |=> !dec_learn); // R6

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_ok && in_st == PS_DIS) |=> (dec_emask == '0)); // R8

  AST_EGRESS_FORWARDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((dec_emask & ~$past(snf_ports) & ~$past(fwd_ports)) == '0)); // R4

  AST_BAD_INGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_ok) |=> (dec_emask == '0 && !dec_learn)); // R12

endmodule

bind swf_egress_filter swf_egress_filter_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_src   (req_src),
  .dec_valid (dec_valid),
  .dec_emask (dec_emask),
  .dec_learn (dec_learn),
  .state_q   (state_q),
  .mirror_q  (mirror_q)
);

// File: tb/swf_egress_filter_tb.sv
`timescale 1ns/1ps
module swf_egress_filter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_sel;
  logic [8:0] cfg_wdata;
  logic       req_valid;
  logic [1:0] req_src;
  logic [2:0] req_dmask;
  logic       dec_valid, dec_learn;
  logic [2:0] dec_emask;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  swf_egress_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_src(req_src),
    .req_dmask(req_dmask), .dec_valid(dec_valid), .dec_emask(dec_emask),
    .dec_learn(dec_learn)
  );

  // {state[5:0], mirror[8:0], src[1:0], dmask[2:0], exp_mask[2:0], exp_learn}
  localparam int NV = 18;
  localparam logic [23:0] VEC [NV] = '{
    {6'h00, 9'h000, 2'd0, 3'b110, 3'b110, 1'b1},  // R4 all forwarding
    {6'h00, 9'h000, 2'd1, 3'b111, 3'b101, 1'b1},  // R10 self removed
    {6'h10, 9'h000, 2'd0, 3'b110, 3'b010, 1'b1},  // R4 port2 blocking
    {6'h08, 9'h000, 2'd1, 3'b101, 3'b000, 1'b1},  // R5 learning ingress
    {6'h04, 9'h000, 2'd1, 3'b001, 3'b000, 1'b0},  // R6 blocking ingress
    {6'h0C, 9'h000, 2'd1, 3'b001, 3'b000, 1'b0},  // R5 disabled ingress
    {6'h14, 9'h13A, 2'd1, 3'b100, 3'b001, 1'b0},  // R8 separation p1
    {6'h14, 9'h13A, 2'd2, 3'b010, 3'b001, 1'b0},  // R8 separation p2
    {6'h14, 9'h13A, 2'd0, 3'b110, 3'b000, 1'b1},  // R4 host to blocked
    {6'h14, 9'h03A, 2'd1, 3'b100, 3'b000, 1'b0},  // R8 no sniff-all
    {6'h1C, 9'h13A, 2'd1, 3'b100, 3'b000, 1'b0},  // R8 disabled ingress
    {6'h00, 9'h086, 2'd0, 3'b010, 3'b110, 1'b1},  // R8 rx mirror fwd
    {6'h00, 9'h031, 2'd1, 3'b100, 3'b101, 1'b1},  // R9 tx mirror
    {6'h00, 9'h031, 2'd1, 3'b000, 3'b000, 1'b1},  // R9 no mirrored egress
    {6'h10, 9'h031, 2'd1, 3'b100, 3'b000, 1'b1},  // R9 mirrored egress blocked
    {6'h00, 9'h026, 2'd0, 3'b000, 3'b000, 1'b1},  // R10 ingress is sniffer
    {6'h00, 9'h000, 2'd3, 3'b111, 3'b000, 1'b0},  // R12 no such port
    {6'h14, 9'h138, 2'd1, 3'b100, 3'b000, 1'b0}   // R7 enables clear
  };
  localparam logic [23:0] VTAG [NV] = '{
    "R4 ", "R10", "R4 ", "R5 ", "R6 ", "R5 ", "R8 ", "R8 ", "R4 ",
    "R8 ", "R8 ", "R8 ", "R9 ", "R9 ", "R9 ", "R10", "R12", "R7 "
  };

  task automatic check(input string tag, input logic [2:0] exp_m,
                       input logic exp_l, input logic exp_v);
    n_tests++;
    if (dec_emask !== exp_m || dec_learn !== exp_l || dec_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got valid=%b mask=%b learn=%b, expected valid=%b mask=%b learn=%b",
               tag, dec_valid, dec_emask, dec_learn, exp_v, exp_m, exp_l);
    end
  endtask

  task automatic wr(input logic sel, input logic [8:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at a negedge, registered on the posedge, sampled at the next negedge
  task automatic ask(input logic [1:0] src, input logic [2:0] dm);
    req_valid = 1'b1; req_src = src; req_dmask = dm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_src = '0; req_dmask = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 3'b000, 1'b0, 1'b0);

    // table walk: R2 field encodings exercised through each state value
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, {3'b000, VEC[i][23:18]});
      wr(1'b1, VEC[i][17:9]);
      ask(VEC[i][8:7], VEC[i][6:4]);
      check($sformatf("%s vec %0d", VTAG[i], i), VEC[i][3:1], VEC[i][0], 1'b1);
    end

    // R3: cycle after the request, with no new request, is quiet
    @(negedge clk);
    check("R3 idle", 3'b000, 1'b0, 1'b0);

    // R11: write and request in the same cycle
    wr(1'b0, 9'h000);
    wr(1'b1, 9'h000);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 9'h003;   // port0 disabled
    ask(2'd0, 3'b110);
    cfg_we = 1'b0;
    check("R11 old value", 3'b110, 1'b1, 1'b1);
    ask(2'd0, 3'b110);
    check("R11 new value", 3'b000, 1'b0, 1'b1);

    // R2: learning code on port 0 selects learn without forwarding
    wr(1'b0, 9'h002);
    ask(2'd0, 3'b110);
    check("R2 learning code", 3'b000, 1'b1, 1'b1);

    // R1: reset mid-run restores forwarding state and clears mirroring
    wr(1'b0, 9'h03F);
    wr(1'b1, 9'h031);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 3'b000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    ask(2'd1, 3'b100);
    check("R1 defaults", 3'b100, 1'b1, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule